// File: doc/BRIEF.md
# Converter Conversion-Mode Sequencer

This block is the timing core on the device side of a sampling converter. It has one asynchronous conversion-start input. From it the block derives three things: the track/hold control, a busy flag, and a status that says whether the converter is awake or asleep. It does not convert anything itself. It only decides when the sample is frozen, how long conversion lasts and when the result becomes valid. When busy falls it can copy a supplied result word into an output register.

There is no mode register. The mode follows from the level of the start input at the moment a conversion ends. If start is high at that point, the block stays awake and the next falling edge of start begins a new conversion at once. If start is low, the block falls asleep. A later rising edge of start then begins a timed wake-up interval. In that case the instant of hold depends on the width of the start pulse. A short pulse lets the sequencer take the sample by itself when wake-up ends. A long pulse places the sample on the falling edge of the pulse. A falling edge that lands in the middle band, while the wake-up logic is still active, still produces a sample, but that sample is marked as degraded.

All intervals are counts of system clock cycles. By default they are derived from a clock frequency parameter in MHz, using 5 us for conversion, 5 us for wake-up, 2 us for the short-pulse limit and 6 us for the long-pulse limit. The start input is synchronised by two flops, and an edge on it takes effect on the third rising clock edge after the input changes.

Top module: `convmode_seq`

## Requirements
- R1: While reset is held, and directly after it is released, hold_o=0, busy_o=0, awake_o=1, degraded_o=0, overrun_o=0 and data_o=0.
- R2: When the block is awake and idle, a falling edge on start_i raises hold_o and busy_o together on the third rising clock edge after the input changes. awake_o stays 1 throughout.
- R3: hold_o stays high for exactly CONV_CYC clock cycles, and hold_o and busy_o then fall on the same edge. On that edge data_o takes the value of result_i. At every other edge data_o keeps its value.
- R4: The level of start_i when busy_o falls sets the next mode: high gives awake_o=1 (awake, idle), low gives awake_o=0 (asleep).
- R5: When the block is asleep, a rising edge on start_i raises busy_o on the third clock edge after the input changes, while awake_o stays 0. If the pulse is at most WAKE_CYC cycles wide, hold_o rises WAKE_CYC cycles later, that is 3+WAKE_CYC edges after the rise.
- R6: When the block is asleep and the start pulse is W > WAKE_CYC cycles wide, hold_o rises on the third edge after the falling input change, that is 3+W edges after the rise. awake_o becomes 1 when the wake-up interval ends.
- R7: For a start pulse that wakes the block, degraded_o is set when its width W satisfies SHORT_CYC < W < LONG_CYC. For other widths it stays 0. degraded_o is cleared when the next conversion sequence starts (a fall seen while awake and idle, or a rise seen while asleep).
- R8: A falling edge on start_i during conversion does not change the hold or busy timing. It sets overrun_o, which stays 1 until reset.
- R9: A rising edge on start_i while the block is awake and idle, or during conversion, has no effect on hold_o, busy_o or awake_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Conversion-start request, asynchronous |
| result_i | input | RES_W | Result word captured when busy falls |
| hold_o | output | 1 | Track/hold control, 1 = hold |
| busy_o | output | 1 | Wake-up or conversion in progress |
| awake_o | output | 1 | 1 = awake, 0 = asleep or still waking |
| degraded_o | output | 1 | Last sample was taken during wake-up activity |
| overrun_o | output | 1 | Sticky: a start edge arrived during conversion |
| data_o | output | RES_W | Registered result |

## Verification
The high-throughput path is exercised with start-low pulses of different widths that end high or low. This separates the fixed three-edge latency and the conversion length from the mode decision made at busy fall. The sleep path is driven with pulse widths at both sides of every limit: 1, SHORT_CYC, SHORT_CYC+1, WAKE_CYC, WAKE_CYC+1, LONG_CYC-1 and LONG_CYC. These cases show the self-timed and edge-timed hold instants apart, and they show whether the degraded band is decoded correctly. Random chains of both sequences, with random result words, then test that each mode decision carries correctly into the next sequence. Directed cases place a stray rise in the idle state and an extra fall during conversion; these show that the ignored edges really leave the timing unchanged.

// File: rtl/convmode_seq_pkg.sv
package convmode_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_CONV  = 3'd1,
    ST_SLEEP = 3'd2,
    ST_WAKE  = 3'd3,
    ST_WAIT  = 3'd4
  } seq_state_e;
endpackage

// File: rtl/convmode_seq_sync.sv
module convmode_seq_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) sync_q[0] <= 1'b0;
          else         sync_q[0] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) sync_q[i] <= 1'b0;
          else         sync_q[i] <= sync_q[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_q <= 1'b0;
    else         last_q <= sync_q[STAGES-1];
  end

  assign level_o = sync_q[STAGES-1];
  assign rise_o  = sync_q[STAGES-1] & ~last_q;
  assign fall_o  = ~sync_q[STAGES-1] & last_q;
endmodule

// File: rtl/convmode_seq_fsm.sv
module convmode_seq_fsm
  import convmode_seq_pkg::*;
#(
  parameter int unsigned CONV_CYC  = 1250,
  parameter int unsigned WAKE_CYC  = 1250,
  parameter int unsigned SHORT_CYC = 500,
  parameter int unsigned LONG_CYC  = 1500
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  input  logic rise_i,
  input  logic fall_i,
  output logic hold_o,
  output logic busy_o,
  output logic awake_o,
  output logic degraded_o,
  output logic overrun_o,
  output logic load_o
);
  localparam int unsigned MAX_A = (CONV_CYC > WAKE_CYC) ? CONV_CYC : WAKE_CYC;
  localparam int unsigned MAX_C = (MAX_A > LONG_CYC) ? MAX_A : LONG_CYC;
  localparam int unsigned CW    = $clog2(MAX_C + 1);
  localparam logic [CW-1:0] CONV_LAST = CW'(CONV_CYC - 1);
  localparam logic [CW-1:0] WAKE_LAST = CW'(WAKE_CYC - 1);
  localparam logic [CW-1:0] SHORT_C   = CW'(SHORT_CYC);
  localparam logic [CW-1:0] LONG_LAST = CW'(LONG_CYC - 1);
  localparam logic [CW-1:0] LONG_C    = CW'(LONG_CYC);

  seq_state_e    state_q;
  logic [CW-1:0] cnt_q;
  logic          fell_q, degr_q, ovr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      fell_q  <= 1'b0;
      degr_q  <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (fall_i) begin
            state_q <= ST_CONV;
            cnt_q   <= '0;
            degr_q  <= 1'b0;
          end
        end
        ST_CONV: begin
          if (fall_i) ovr_q <= 1'b1;
          if (cnt_q == CONV_LAST) begin
            state_q <= lvl_i ? ST_IDLE : ST_SLEEP;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_SLEEP: begin
          if (rise_i) begin
            state_q <= ST_WAKE;
            cnt_q   <= '0;
            fell_q  <= 1'b0;
            degr_q  <= 1'b0;
          end
        end
        ST_WAKE: begin
          if (fall_i) begin
            if (fell_q) ovr_q <= 1'b1;
            else begin
              fell_q <= 1'b1;
              // falling edge inside wake-up activity
              if (cnt_q >= SHORT_C) degr_q <= 1'b1;
            end
          end
          if (cnt_q == WAKE_LAST) begin
            if (fell_q || fall_i) begin
              state_q <= ST_CONV;
              cnt_q   <= '0;
            end else begin
              state_q <= ST_WAIT;
              cnt_q   <= cnt_q + 1'b1;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_WAIT: begin
          if (fall_i) begin
            if (cnt_q < LONG_LAST) degr_q <= 1'b1;
            state_q <= ST_CONV;
            cnt_q   <= '0;
          end else if (cnt_q < LONG_C) begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign hold_o     = (state_q == ST_CONV);
  assign busy_o     = (state_q == ST_CONV) || (state_q == ST_WAKE) || (state_q == ST_WAIT);
  assign awake_o    = (state_q == ST_IDLE) || (state_q == ST_CONV) || (state_q == ST_WAIT);
  assign degraded_o = degr_q;
  assign overrun_o  = ovr_q;
  assign load_o     = (state_q == ST_CONV) && (cnt_q == CONV_LAST);
endmodule

// File: rtl/convmode_seq_result.sv
module convmode_seq_result #(
  parameter int unsigned RES_W   = 14,
  parameter bit          HAS_REG = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [RES_W-1:0] res_i,
  output logic [RES_W-1:0] data_o
);
  generate
    if (HAS_REG) begin : g_reg
      logic [RES_W-1:0] data_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     data_q <= '0;
        else if (load_i) data_q <= res_i;
      end
      assign data_o = data_q;
    end else begin : g_none
      logic unused_w;
      assign unused_w = load_i ^ (^res_i) ^ clk_i ^ rst_ni;
      assign data_o   = '0;
    end
  endgenerate
endmodule

// File: rtl/convmode_seq.sv
module convmode_seq #(
  parameter int unsigned CLK_MHZ   = 250,
  parameter int unsigned CONV_CYC  = 5 * CLK_MHZ,
  parameter int unsigned WAKE_CYC  = 5 * CLK_MHZ,
  parameter int unsigned SHORT_CYC = 2 * CLK_MHZ,
  parameter int unsigned LONG_CYC  = 6 * CLK_MHZ,
  parameter int unsigned RES_W     = 14,
  parameter bit          HAS_REG   = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [RES_W-1:0] result_i,
  output logic             hold_o,
  output logic             busy_o,
  output logic             awake_o,
  output logic             degraded_o,
  output logic             overrun_o,
  output logic [RES_W-1:0] data_o
);
  logic lvl_w, rise_w, fall_w, load_w;

  convmode_seq_sync #(.STAGES(2)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (start_i),
    .level_o (lvl_w),
    .rise_o  (rise_w),
    .fall_o  (fall_w)
  );

  convmode_seq_fsm #(
    .CONV_CYC  (CONV_CYC),
    .WAKE_CYC  (WAKE_CYC),
    .SHORT_CYC (SHORT_CYC),
    .LONG_CYC  (LONG_CYC)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lvl_i      (lvl_w),
    .rise_i     (rise_w),
    .fall_i     (fall_w),
    .hold_o     (hold_o),
    .busy_o     (busy_o),
    .awake_o    (awake_o),
    .degraded_o (degraded_o),
    .overrun_o  (overrun_o),
    .load_o     (load_w)
  );

  convmode_seq_result #(.RES_W(RES_W), .HAS_REG(HAS_REG)) u_res (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_w),
    .res_i  (result_i),
    .data_o (data_o)
  );
endmodule

// File: rtl/convmode_seq_chk.sv
module convmode_seq_chk #(
  parameter int unsigned CONV_CYC = 1250,
  parameter int unsigned RES_W    = 14
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             hold_o,
  input logic             busy_o,
  input logic             awake_o,
  input logic             overrun_o,
  input logic [RES_W-1:0] data_o
);
  int unsigned hold_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     hold_cnt <= 0;
    else if (hold_o) hold_cnt <= hold_cnt + 1;
    else             hold_cnt <= 0;
  end

  // R3
  hold_in_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_o |-> busy_o);

  // R3
  hold_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hold_o) |-> (hold_cnt == CONV_CYC));

  // R3
  busy_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> !hold_o);

  // R3
  data_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$fell(busy_o) |-> $stable(data_o));

  // R2
  fast_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(busy_o) && awake_o) |-> hold_o);

  // R8
  overrun_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |=> overrun_o);
endmodule

bind convmode_seq convmode_seq_chk #(.CONV_CYC(CONV_CYC), .RES_W(RES_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .hold_o    (hold_o),
  .busy_o    (busy_o),
  .awake_o   (awake_o),
  .overrun_o (overrun_o),
  .data_o    (data_o)
);

// File: tb/convmode_seq_test.sv
`timescale 1ns/1ps
module convmode_seq_test;
  localparam int CONV  = 30;
  localparam int WAKE  = 30;
  localparam int SHORT = 12;
  localparam int LONG  = 36;
  localparam int RW    = 14;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [RW-1:0] res = '0;
  logic          hold, busy, awake, degr, ovr;
  logic [RW-1:0] data;

  int checks = 0, errors = 0, cyc = 0;
  int hold_rise, hold_fall, busy_rise, busy_fall, awake_at_busy;
  logic hold_q = 1'b0, busy_q = 1'b0;
  bit exp_ovr = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  convmode_seq #(
    .CONV_CYC(CONV), .WAKE_CYC(WAKE), .SHORT_CYC(SHORT), .LONG_CYC(LONG), .RES_W(RW)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .result_i(res),
    .hold_o(hold), .busy_o(busy), .awake_o(awake), .degraded_o(degr),
    .overrun_o(ovr), .data_o(data)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (hold && !hold_q) hold_rise = cyc;
    if (!hold && hold_q) hold_fall = cyc;
    if (busy && !busy_q) begin busy_rise = cyc; awake_at_busy = awake; end
    if (!busy && busy_q) busy_fall = cyc;
    hold_q = hold;
    busy_q = busy;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_hold_lat(input int w);
    return 3 + ((w > WAKE) ? w : WAKE);
  endfunction

  function automatic bit exp_degr(input int w);
    return (w > SHORT) && (w < LONG);
  endfunction

  task automatic clear_marks();
    hold_rise = -1; hold_fall = -1; busy_rise = -1; busy_fall = -1; awake_at_busy = -1;
  endtask

  task automatic wait_done();
    repeat (4) @(negedge clk);
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic run_fast(input int low_w, input bit end_high, input bit extra_fall);
    logic [RW-1:0] v;
    int t0;
    v = RW'($urandom);
    clear_marks();
    @(negedge clk);
    res = v;
    start = 1'b0;
    t0 = cyc;
    repeat (low_w) @(negedge clk);
    if (end_high) start = 1'b1;
    if (extra_fall) begin
      repeat (8) @(negedge clk);
      start = 1'b0;
      repeat (2) @(negedge clk);
      start = 1'b1;
      exp_ovr = 1'b1;
    end
    wait_done();
    chk(hold_rise - t0 == 3, "R2 hold latency", hold_rise - t0, 3);
    chk(busy_rise == hold_rise, "R2 busy with hold", busy_rise, hold_rise);
    chk(awake_at_busy == 1, "R2 awake during fast conv", awake_at_busy, 1);
    chk(hold_fall - hold_rise == CONV, "R3 hold width", hold_fall - hold_rise, CONV);
    chk(busy_fall == hold_fall, "R3 busy ends with hold", busy_fall, hold_fall);
    chk(data == v, "R3 result capture", int'(data), int'(v));
    chk(awake == end_high, "R4 mode from start level", int'(awake), int'(end_high));
    chk(degr == 1'b0, "R7 degraded cleared", int'(degr), 0);
    chk(ovr == exp_ovr, "R8 overrun flag", int'(ovr), int'(exp_ovr));
  endtask

  task automatic run_sleep(input int w, input bit end_high);
    logic [RW-1:0] v;
    int t0;
    v = RW'($urandom);
    clear_marks();
    @(negedge clk);
    res = v;
    start = 1'b1;
    t0 = cyc;
    repeat (w) @(negedge clk);
    start = 1'b0;
    if (end_high) begin
      while (!hold) @(negedge clk);
      repeat (4) @(negedge clk);
      start = 1'b1;   // R9 rise during conversion must be ignored
    end
    wait_done();
    chk(busy_rise - t0 == 3, "R5 busy on wake", busy_rise - t0, 3);
    chk(awake_at_busy == 0, "R5 asleep while waking", awake_at_busy, 0);
    if (w <= WAKE)
      chk(hold_rise - t0 == exp_hold_lat(w), "R5 self-timed hold", hold_rise - t0, exp_hold_lat(w));
    else
      chk(hold_rise - t0 == exp_hold_lat(w), "R6 edge-timed hold", hold_rise - t0, exp_hold_lat(w));
    chk(hold_fall - hold_rise == CONV, "R3 R9 hold width", hold_fall - hold_rise, CONV);
    chk(data == v, "R3 result capture", int'(data), int'(v));
    chk(awake == end_high, "R4 mode from start level", int'(awake), int'(end_high));
    chk(degr == exp_degr(w), "R7 degraded flag", int'(degr), int'(exp_degr(w)));
    chk(ovr == exp_ovr, "R8 overrun flag", int'(ovr), int'(exp_ovr));
  endtask

  initial begin
    #800000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit aw;
    int unsigned seed_v;
    seed_v = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    chk(!hold && !busy && awake && !degr && !ovr && data == '0, "R1 reset state in reset",
        {hold, busy, awake, degr, ovr}, 5'b00100);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!hold && !busy && awake && !degr && !ovr && data == '0, "R1 reset state after release",
        {hold, busy, awake, degr, ovr}, 5'b00100);

    // R9: rise while idle
    start = 1'b1;
    repeat (10) @(negedge clk);
    chk(!busy && !hold && awake, "R9 idle rise ignored", {hold, busy, awake}, 3'b001);

    run_fast(2, 1'b1, 1'b0);
    run_fast(1, 1'b1, 1'b0);
    run_fast(6, 1'b0, 1'b0);
    chk(awake == 1'b0, "R4 asleep after low end", int'(awake), 0);

    run_sleep(1, 1'b0);
    run_sleep(SHORT, 1'b0);
    run_sleep(SHORT + 1, 1'b0);
    run_sleep(WAKE, 1'b0);
    run_sleep(WAKE + 1, 1'b0);
    run_sleep(LONG - 1, 1'b0);
    run_sleep(LONG, 1'b1);

    run_fast(3, 1'b1, 1'b1);   // R8 extra fall during conversion
    aw = 1'b1;
    for (int i = 0; i < 24; i++) begin
      bit eh;
      eh = 1'($urandom % 2);
      if (aw) run_fast(1 + int'($urandom % 20), eh, 1'b0);
      else    run_sleep(1 + int'($urandom % 50), eh);
      aw = eh;
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule